// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns the peripheral clock into the timing grid of one classic CAN nominal bit. A prescaler cuts the clock into time quanta, and a sequencer walks each bit through a one-quantum synchronisation segment, a first phase segment that also absorbs propagation delay, and a second phase segment. The sequencer pulses a sample strobe on the last clock of the first phase segment. It pulses a transmit strobe on the first clock of every bit.

The timing fields arrive register-encoded, each holding its value minus one. They are copied into shadow registers only when a bit starts, so a bit that is already running always finishes with the timing it began with. A configuration whose resynchronisation jump width is larger than the second phase segment is flagged at once and is never copied. A recessive-to-dominant edge indication moves the sample point: it stretches the first phase segment or trims the second, by no more than the jump width and at most once per bit. A hard-sync input restarts the bit immediately.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` is high for exactly one clock at the end of every time quantum, and a quantum lasts `brp_cfg + 1` clocks.
- R2: With no bus edge, a bit lasts `(brp_cfg+1) * (1 + (ph1_cfg+1) + (ph2_cfg+1))` clocks. `tx_stb` is high on the first clock of each bit and on no other clock.
- R3: `sample_stb` is high on the last clock of the first phase segment. That is `(brp_cfg+1)*(1+ph1_cfg+1) - 1` clocks after the bit's `tx_stb` clock.
- R4: `seg_now` encodes the segment as 0 = synchronisation, 1 = first phase, 2 = second phase. It reads 0 on a `tx_stb` clock, 1 on a `sample_stb` clock and 2 on the clock after a sample.
- R5: `cfg_bad` is high in the same clock, combinationally, whenever `sjw_cfg > ph2_cfg`. The jump width field also uses the minus-one encoding, so `sjw_cfg + 1` quanta. `cfg_bad` is low when the two fields are equal.
- R6: While `cfg_bad` is high, no field is taken over at a bit start, and bits keep the timing last accepted.
- R7: Field changes take effect only at the next bit start (end of the second phase segment or a hard sync). The bit in progress keeps its old length.
- R8: A `bus_fall` pulse during quantum k (counted from 0) of the first phase segment lengthens that segment by min(k+1, sjw_cfg+1) quanta. This moves the sample strobe and the bit end by that amount.
- R9: A `bus_fall` pulse during quantum k of the second phase segment, whose nominal length is T2 = ph2_cfg+1, shortens it by min(T2-k-1, sjw_cfg+1) quanta.
- R10: Only the first `bus_fall` pulse outside the synchronisation segment acts in each bit. Pulses during the synchronisation segment have no effect.
- R11: A `hard_sync` pulse in clock h makes clock h+1 the first clock of a new bit, with the prescaler restarted. No `sample_stb` occurs in clock h.
- R12: After a synchronous reset, the first clock is a bit start in segment 0. The fields present during reset are loaded, with the jump width clamped to `ph2_cfg` when it is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| hard_sync | input | 1 | Restart the bit at the synchronisation segment |
| bus_fall | input | 1 | One-clock pulse marking a recessive-to-dominant bus edge |
| brp_cfg | input | 6 | Prescaler, clocks per quantum minus one |
| ph1_cfg | input | 4 | First phase segment length in quanta minus one |
| ph2_cfg | input | 3 | Second phase segment length in quanta minus one |
| sjw_cfg | input | 2 | Resynchronisation jump width in quanta minus one |
| tq_tick | output | 1 | Last clock of a time quantum |
| seg_now | output | 2 | Current segment: 0 sync, 1 first phase, 2 second phase |
| sample_stb | output | 1 | Sample point strobe |
| tx_stb | output | 1 | First clock of a bit (transmit point) |
| cfg_bad | output | 1 | Jump width exceeds the second phase segment |

## Verification
The bench drives inputs one nanosecond after a rising edge and reads outputs on the falling edge. It stamps every `tx_stb`, `sample_stb` and `tq_tick` with the clock number. `cfg_bad` is due in the same clock as the field change. A hard sync gives `tx_stb` exactly one clock later. Sample strobes and bit ends fall a whole number of quanta after the bit's `tx_stb`, less one clock for the sample. Each check compares these stamps against offsets that bench functions compute from the decoded fields and the quantum in which a bus edge was placed. New fields are judged only from the bit after the next boundary.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  // register field holding n means n+1 units
  function automatic int unsigned decode_q(input int unsigned field);
    return field + 32'd1;
  endfunction

  // legality of jump width against the second phase segment (both encoded)
  function automatic logic jump_fits(input int unsigned jump_f, input int unsigned ph2_f);
    return (jump_f <= ph2_f);
  endfunction

  // lengthening for an edge seen in first-phase quantum q_idx
  function automatic int unsigned lengthen_q(input int unsigned q_idx, input int unsigned jump);
    int unsigned err;
    err = q_idx + 32'd1;
    return (err < jump) ? err : jump;
  endfunction

  // shortening for an edge seen in second-phase quantum q_idx
  function automatic int unsigned shorten_q(input int unsigned q_idx, input int unsigned ph2_len,
                                            input int unsigned jump);
    int unsigned left;
    left = ph2_len - q_idx - 32'd1;
    return (left < jump) ? left : jump;
  endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int PH1_W = 4,
  parameter int PH2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BRP_W-1:0] brp_in,
  input  logic [PH1_W-1:0] ph1_in,
  input  logic [PH2_W-1:0] ph2_in,
  input  logic [SJW_W-1:0] sjw_in,
  output logic [BRP_W-1:0] brp_q,
  output logic [PH1_W-1:0] ph1_q,
  output logic [PH2_W-1:0] ph2_q,
  output logic [SJW_W-1:0] sjw_q,
  output logic             bad_cfg
);

  assign bad_cfg = !jump_fits(32'(sjw_in), 32'(ph2_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      brp_q <= brp_in;
      ph1_q <= ph1_in;
      ph2_q <= ph2_in;
      sjw_q <= bad_cfg ? SJW_W'(ph2_in) : sjw_in;
    end else if (load && !bad_cfg) begin
      brp_q <= brp_in;
      ph1_q <= ph1_in;
      ph2_q <= ph2_in;
      sjw_q <= sjw_in;
    end
  end

  // R6
  act_legal_chk: assert property (@(posedge clk) disable iff (rst)
    32'(sjw_q) <= 32'(ph2_q));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({brp_q, ph1_q, ph2_q, sjw_q}));

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp_q,
  output logic             tq_tick,
  output logic [BRP_W-1:0] pre_cnt
);

  localparam logic [BRP_W-1:0] ONE_C = BRP_W'(1);

  assign tq_tick = (pre_cnt == brp_q) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart || tq_tick) pre_cnt <= '0;
    else                           pre_cnt <= pre_cnt + ONE_C;
  end

  // R1
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= brp_q);

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int PH1_W = 4,
  parameter int PH2_W = 3,
  parameter int SJW_W = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hard_sync,
  input  logic             tq_tick,
  input  logic             bus_fall,
  input  logic [PH1_W-1:0] ph1_q,
  input  logic [PH2_W-1:0] ph2_q,
  input  logic [SJW_W-1:0] sjw_q,
  output seg_e             seg,
  output logic             sample_pt,
  output logic             bit_done,
  output logic             lengthen_ev,
  output logic             shorten_ev
);

  localparam logic [CNT_W-1:0] ONE_Q = CNT_W'(1);

  logic [CNT_W-1:0] q_cnt;
  logic [CNT_W-1:0] stretch_r, cut_r;
  logic             synced_r;
  logic [CNT_W-1:0] ph1_len, ph2_len, jump;
  logic [CNT_W-1:0] stretch_now, cut_now;
  logic             edge_ok, ph1_last, ph2_last;

  assign ph1_len = CNT_W'(decode_q(32'(ph1_q)));
  assign ph2_len = CNT_W'(decode_q(32'(ph2_q)));
  assign jump    = CNT_W'(decode_q(32'(sjw_q)));

  assign edge_ok     = bus_fall && !hard_sync && !synced_r && (seg != SEG_SYNC);
  assign lengthen_ev = edge_ok && (seg == SEG_PH1);
  assign shorten_ev  = edge_ok && (seg == SEG_PH2);

  assign stretch_now = lengthen_ev ? CNT_W'(lengthen_q(32'(q_cnt), 32'(jump))) : stretch_r;
  assign cut_now     = shorten_ev  ? CNT_W'(shorten_q(32'(q_cnt), 32'(ph2_len), 32'(jump)))
                                   : cut_r;

  assign ph1_last  = (seg == SEG_PH1) && (q_cnt == ph1_len + stretch_now - ONE_Q);
  assign ph2_last  = (seg == SEG_PH2) && (q_cnt == ph2_len - cut_now - ONE_Q);
  assign sample_pt = tq_tick && ph1_last;
  assign bit_done  = tq_tick && ph2_last;

  always_ff @(posedge clk) begin
    if (rst || hard_sync) begin
      seg       <= SEG_SYNC;
      q_cnt     <= '0;
      stretch_r <= '0;
      cut_r     <= '0;
      synced_r  <= 1'b0;
    end else begin
      if (edge_ok) begin
        synced_r  <= 1'b1;
        stretch_r <= stretch_now;
        cut_r     <= cut_now;
      end
      if (tq_tick) begin
        unique case (seg)
          SEG_SYNC: begin
            seg   <= SEG_PH1;
            q_cnt <= '0;
          end
          SEG_PH1: begin
            if (ph1_last) begin
              seg   <= SEG_PH2;
              q_cnt <= '0;
            end else begin
              q_cnt <= q_cnt + ONE_Q;
            end
          end
          SEG_PH2: begin
            if (ph2_last) begin
              seg       <= SEG_SYNC;
              q_cnt     <= '0;
              stretch_r <= '0;
              cut_r     <= '0;
              synced_r  <= 1'b0;
            end else begin
              q_cnt <= q_cnt + ONE_Q;
            end
          end
          default: begin
            seg   <= SEG_SYNC;
            q_cnt <= '0;
          end
        endcase
      end
    end
  end

  // R8
  stretch_cap_chk: assert property (@(posedge clk) disable iff (rst)
    stretch_r <= jump);

  // R9
  cut_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cut_r < ph2_len);

  // R10
  adj_once_chk: assert property (@(posedge clk) disable iff (rst)
    (synced_r && !hard_sync && !bit_done) |=> ($stable(stretch_r) && $stable(cut_r)));

  // R4
  seg_valid_chk: assert property (@(posedge clk) disable iff (rst)
    seg != 2'd3);

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int PH1_W = 4,
  parameter int PH2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hard_sync,
  input  logic             bus_fall,
  input  logic [BRP_W-1:0] brp_cfg,
  input  logic [PH1_W-1:0] ph1_cfg,
  input  logic [PH2_W-1:0] ph2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  output logic             tq_tick,
  output logic [1:0]       seg_now,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             cfg_bad
);

  localparam int SEG_MAXW = (PH1_W > PH2_W) ? PH1_W : PH2_W;
  localparam int CNT_W    = ((SEG_MAXW > SJW_W) ? SEG_MAXW : SJW_W) + 2;

  logic [BRP_W-1:0] brp_q;
  logic [PH1_W-1:0] ph1_q;
  logic [PH2_W-1:0] ph2_q;
  logic [SJW_W-1:0] sjw_q;
  logic [BRP_W-1:0] pre_cnt;
  logic             reload_evt, bit_done, sample_pt, lengthen_ev, shorten_ev;
  seg_e             seg_q;

  assign reload_evt = bit_done || hard_sync;

  can_bt_cfg #(
    .BRP_W(BRP_W), .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load   (reload_evt),
    .brp_in (brp_cfg),
    .ph1_in (ph1_cfg),
    .ph2_in (ph2_cfg),
    .sjw_in (sjw_cfg),
    .brp_q  (brp_q),
    .ph1_q  (ph1_q),
    .ph2_q  (ph2_q),
    .sjw_q  (sjw_q),
    .bad_cfg(cfg_bad)
  );

  can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .restart(hard_sync),
    .brp_q  (brp_q),
    .tq_tick(tq_tick),
    .pre_cnt(pre_cnt)
  );

  can_bt_seq #(
    .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .hard_sync  (hard_sync),
    .tq_tick    (tq_tick),
    .bus_fall   (bus_fall),
    .ph1_q      (ph1_q),
    .ph2_q      (ph2_q),
    .sjw_q      (sjw_q),
    .seg        (seg_q),
    .sample_pt  (sample_pt),
    .bit_done   (bit_done),
    .lengthen_ev(lengthen_ev),
    .shorten_ev (shorten_ev)
  );

  assign seg_now    = seg_q;
  assign sample_stb = sample_pt;
  assign tx_stb     = (seg_q == SEG_SYNC) && (pre_cnt == '0);

  // R11
  hs_restart_chk: assert property (@(posedge clk) disable iff (rst)
    hard_sync |=> (tx_stb && seg_now == 2'd0));

  // R3
  sample_then_ph2_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> (seg_now == 2'd2));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_stb, tx_stb, lengthen_ev && shorten_ev}));

  // R2
  bit_end_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_done && !hard_sync) |=> tx_stb);

endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;

  localparam int WD_LIMIT = 120000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hard_sync = 1'b0;
  logic       bus_fall = 1'b0;
  logic [5:0] brp_cfg;
  logic [3:0] ph1_cfg;
  logic [2:0] ph2_cfg;
  logic [1:0] sjw_cfg;
  logic       tq_tick, sample_stb, tx_stb, cfg_bad;
  logic [1:0] seg_now;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int tx_seen = 0;
  int last_tx = 0, prev_tx = 0, last_smp = 0, last_tick = 0, prev_tick = 0;

  can_bit_timer uut (
    .clk(clk), .rst(rst), .hard_sync(hard_sync), .bus_fall(bus_fall),
    .brp_cfg(brp_cfg), .ph1_cfg(ph1_cfg), .ph2_cfg(ph2_cfg), .sjw_cfg(sjw_cfg),
    .tq_tick(tq_tick), .seg_now(seg_now), .sample_stb(sample_stb),
    .tx_stb(tx_stb), .cfg_bad(cfg_bad)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // event stamps, taken away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_stb) begin
        prev_tx = last_tx; last_tx = cyc; tx_seen++;
        chk_eq("R4 seg on tx", int'(seg_now), 0);
      end
      if (sample_stb) begin
        last_smp = cyc;
        chk_eq("R4 seg on sample", int'(seg_now), 1);
      end
      if (tq_tick) begin prev_tick = last_tick; last_tick = cyc; end
    end
  end

  always @(posedge clk) begin
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog all reqs actual %0d expected below %0d", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic goto_cycle(input int target);
    while (cyc < target) step();
  endtask

  task automatic wait_tx();
    int n;
    n = tx_seen;
    while (tx_seen == n) step();
  endtask

  task automatic set_cfg(input int b, input int p1, input int p2, input int sj);
    brp_cfg = 6'(b); ph1_cfg = 4'(p1); ph2_cfg = 3'(p2); sjw_cfg = 2'(sj);
  endtask

  // expected bit length and sample offset from decoded values and edge offset d
  function automatic void predict(input int b, input int t1, input int t2, input int s,
                                  input int d, output int per, output int smp);
    int q, ext, cut, k;
    ext = 0; cut = 0;
    if (d >= 0) begin
      q = d / b;
      if (q >= 1 && q <= t1) ext = (q < s) ? q : s;
      else if (q > t1) begin
        k = q - 1 - t1;
        cut = ((t2 - k - 1) < s) ? (t2 - k - 1) : s;
      end
    end
    per = b * (1 + t1 + t2 + ext - cut);
    smp = b * (1 + t1 + ext) - 1;
  endfunction

  // called right after a tx stamp; optional edge d clocks into the bit
  task automatic run_bit(input int d, input int b, input int t1, input int t2, input int s,
                         input string tag);
    int t0, per, smp;
    t0 = last_tx;
    if (d >= 0) begin
      goto_cycle(t0 + d);
      bus_fall = 1'b1; step(); bus_fall = 1'b0;
    end
    wait_tx();
    predict(b, t1, t2, s, d, per, smp);
    chk_eq({tag, " bit length"}, last_tx - t0, per);
    chk_eq({tag, " sample offset"}, last_smp - t0, smp);
    chk_eq("R1 quantum spacing", last_tick - prev_tick, b);
  endtask

  initial begin
    int seed_v, t0, h, per, smp;
    seed_v = $urandom(32'd1357);
    // R12: reset with jump width larger than second phase (clamped to T2=2)
    set_cfg(1, 4, 1, 3);
    repeat (4) step();
    rst = 1'b0;
    chk_eq("R12 tx after reset", int'(tx_stb), 1);
    chk_eq("R12 seg after reset", int'(seg_now), 0);
    chk_eq("R12 no sample after reset", int'(sample_stb), 0);
    chk_eq("R5 flag raised", int'(cfg_bad), 1);
    step();
    // edge in quantum 4 (first phase k=3): lengthen min(4, 2)=2
    run_bit(2 * 4, 2, 5, 2, 2, "R12 clamped jump");

    // configuration A: B=3 T1=6 T2=3 S=2
    set_cfg(2, 5, 2, 1);
    #1 chk_eq("R5 flag clear", int'(cfg_bad), 0);
    wait_tx();
    run_bit(-1, 3, 6, 3, 2, "R2 R3 nominal");
    run_bit(1, 3, 6, 3, 2, "R10 edge in sync");
    run_bit(3 * 1, 3, 6, 3, 2, "R8 first quantum");
    run_bit(3 * 8 + 2, 3, 6, 3, 2, "R9 second phase");
    run_bit(3 * 9, 3, 6, 3, 2, "R9 last quantum");

    // R10: two edges, only the first counts
    t0 = last_tx;
    goto_cycle(t0 + 3); bus_fall = 1'b1; step(); bus_fall = 1'b0;
    goto_cycle(t0 + 3 * 8); bus_fall = 1'b1; step(); bus_fall = 1'b0;
    wait_tx();
    chk_eq("R10 second edge ignored", last_tx - t0, 33);
    chk_eq("R10 sample", last_smp - t0, 23);

    // R11: hard sync in first-phase quantum 1
    t0 = last_tx;
    goto_cycle(t0 + 6);
    h = cyc;
    hard_sync = 1'b1; step(); hard_sync = 1'b0;
    wait_tx();
    chk_eq("R11 restart", last_tx, h + 1);
    wait_tx();
    chk_eq("R11 bit length", last_tx - (h + 1), 30);
    chk_eq("R11 sample", last_smp - (h + 1), 20);

    // R7: change mid-bit, old bit keeps its length
    t0 = last_tx;
    goto_cycle(t0 + 2);
    set_cfg(0, 2, 1, 0);
    wait_tx();
    chk_eq("R7 running bit", last_tx - t0, 30);
    run_bit(-1, 1, 3, 2, 1, "R7 new timing");

    // R5/R6: illegal set is flagged and not loaded
    set_cfg(4, 0, 0, 1);
    #1 chk_eq("R5 illegal flagged", int'(cfg_bad), 1);
    wait_tx();
    run_bit(-1, 1, 3, 2, 1, "R6 kept timing");
    set_cfg(3, 7, 1, 1);
    #1 chk_eq("R5 equal fields legal", int'(cfg_bad), 0);
    wait_tx();
    run_bit(5 * 4 + 1, 4, 8, 2, 2, "R8 capped");

    // constrained random timings with optional edges
    for (int i = 0; i < 24; i++) begin
      int b, p1, p2, sj, d;
      b = $urandom % 8; p1 = $urandom % 16; p2 = $urandom % 8; sj = $urandom % 4;
      if (sj > p2) sj = p2;
      set_cfg(b, p1, p2, sj);
      #1 chk_eq("R5 random legal", int'(cfg_bad), 0);
      wait_tx();
      predict(b + 1, p1 + 1, p2 + 1, sj + 1, -1, per, smp);
      d = ($urandom % 2 == 0) ? -1 : 1 + int'($urandom % (per - 1));
      run_bit(d, b + 1, p1 + 1, p2 + 1, sj + 1, "R2 R3 R8 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule